// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the address-latch strobe and the active-low program-fetch strobe that an 8-bit microcontroller core drives onto its external memory bus. The oscillator clock feeds a divide-by-two phase stage. A state sequencer then steps through six states of two phases each, so one machine cycle lasts twelve oscillator clocks. The strobes are decoded from the next sequencer position and registered, so the pads see clean edges. The state and phase are also brought out for the rest of the core.

The core steers the strobes with a few level flags:
- **External execution.** When code runs from external memory, the fetch strobe pulses twice per machine cycle. Otherwise it stays high.
- **External data cycle.** In a machine cycle that accesses external data memory, the first address-latch pulse and both fetch pulses are left out.
- **ALE-off bit.** A bit in the power-control register, written through a small write port, stops address-latch pulsing. The pin is then held high and marked as weakly pulled up.
- **Suspending the ALE-off bit.** The bit is overridden by table-read or external-move instructions, by external execution, and by the idle and power-down modes.

A reset pin is qualified over two full machine cycles before it acts.

Top module: `xbus_strobe_gen`

## Requirements
- R1: `mc_p2` alternates on every oscillator edge. Value 0 means phase 1 and value 1 means phase 2. `mc_state` (0..5 encodes S1..S6) advances after phase 2 and wraps from 5 to 0, giving a 12-clock machine cycle. `mc_first` is high exactly in S1 phase 1.
- R2: With no mode, flag or ALE-off active, `ale` is high in S1P2, S2P1, S4P2 and S5P1 and low elsewhere. It therefore pulses once every 6 oscillator clocks.
- R3: With `ext_exec`=1, `psen_n` is 0 in S1P2, S2P1, S2P2, S4P2, S5P1 and S5P2. With `ext_exec`=0 it stays 1.
- R4: `xdata_cyc` is sampled on the edge that moves S6P2 to S1P1 and applies to that whole machine cycle. When it is set, `ale` stays low in S1P2 and S2P1, and `psen_n` stays 1 for the whole cycle. The second `ale` pulse is unchanged.
- R5: A write with `pcon_we`=1 and `pcon_addr`=0x87 stores bit 5 of `pcon_wdata` as the ALE-off bit. Writes to other addresses are ignored. While the bit is in force, `ale`=1 and `ale_weak`=1.
- R6: The ALE-off bit has no effect while `tbl_or_xmov`=1 or `ext_exec`=1. In that case `ale` pulses as in R2/R4 and `ale_weak`=0.
- R7: With `idle_mode`=1 (and no power-down), `ale`=1, `psen_n`=1 and `ale_weak`=0, and the sequencer keeps running.
- R8: With `pdown_mode`=1, `ale`=0, `psen_n`=0 and `ale_weak`=0, and `mc_state`/`mc_p2` are frozen. Power-down overrides idle.
- R9: Reset is recognised only after `rst_pin` has been sampled high on 24 consecutive edges. Shorter pulses are ignored. While reset is recognised:
  - the sequencer is held at S1P1;
  - `ale`=1, `psen_n`=1 and `ale_weak`=0;
  - the ALE-off bit is cleared.
- R10: Mode and flag inputs reach the strobes on the next oscillator edge. A control-register write reaches them on the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset request, active high |
| ext_exec | input | 1 | Core executes from external program memory |
| xdata_cyc | input | 1 | Coming machine cycle accesses external data memory |
| tbl_or_xmov | input | 1 | Table-read or external-move instruction in progress |
| idle_mode | input | 1 | Idle mode active |
| pdown_mode | input | 1 | Power-down mode active |
| pcon_we | input | 1 | Control-register write strobe |
| pcon_addr | input | 8 | Control-register write address |
| pcon_wdata | input | 8 | Control-register write data |
| ale | output | 1 | Address-latch strobe level |
| ale_weak | output | 1 | ALE held high only by weak pullup |
| psen_n | output | 1 | Program-fetch strobe, active low |
| mc_state | output | 3 | Machine state index, 0..5 = S1..S6 |
| mc_p2 | output | 1 | 1 in phase 2 of a state |
| mc_first | output | 1 | High in S1P1 |

## Verification
The external-data skip and the ALE-off override can act in the same machine cycle. The bench provokes this with a vector that sets the ALE-off bit, raises `tbl_or_xmov` and marks the cycle as a data access. The expected outcome is that suspension restores pulsing while the skip still removes the first pulse. A second collision vector runs idle together with an external data cycle in external execution, where idle must win over both the skip and the fetch pulses. Each vector is judged sample by sample across a full aligned machine cycle, against windows the bench computes from the state and phase indices.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

   typedef enum logic [1:0] {
      SM_RUN   = 2'd0,
      SM_IDLE  = 2'd1,
      SM_PDOWN = 2'd2,
      SM_RESET = 2'd3
   } strobe_mode_e;

   // state index at which window w opens (two windows per machine cycle)
   function automatic int unsigned win_first(input int unsigned w, input int unsigned nst);
      return w * (nst / 2);
   endfunction

   // latch strobe: phase 2 of the opening state, phase 1 of the following one
   function automatic logic ale_hit(input int unsigned st, input logic p2,
                                    input int unsigned s0, input int unsigned nst);
      return ((st == s0) && p2) || ((st == ((s0 + 1) % nst)) && !p2);
   endfunction

   // fetch strobe: phase 2 of the opening state and both phases of the next
   function automatic logic psen_hit(input int unsigned st, input logic p2,
                                     input int unsigned s0, input int unsigned nst);
      return ((st == s0) && p2) || (st == ((s0 + 1) % nst));
   endfunction

endpackage

// File: rtl/rst_qual.sv
module rst_qual #(
   parameter int unsigned HOLD_CLKS = 24
) (
   input  logic clk,
   input  logic pin,
   output logic rst_q
);
   if (HOLD_CLKS < 1) begin : g_chk_hold
      $error("rst_qual: HOLD_CLKS must be at least 1");
   end

   if (HOLD_CLKS == 1) begin : g_direct
      always_ff @(posedge clk) rst_q <= pin;
   end else begin : g_count
      localparam int unsigned CW = $clog2(HOLD_CLKS + 1);
      localparam logic [CW-1:0] LIM = CW'(HOLD_CLKS);
      logic [CW-1:0] cnt_q, cnt_n;

      always_comb begin
         if (!pin)             cnt_n = '0;
         else if (cnt_q == LIM) cnt_n = cnt_q;
         else                  cnt_n = cnt_q + 1'b1;
      end

      always_ff @(posedge clk) begin
         cnt_q <= cnt_n;
         rst_q <= (cnt_n == LIM);
      end

      AST_RST_NEEDS_PIN: assert property (@(posedge clk)
         $rose(rst_q) |-> $past(pin)) else $error("reset rose without pin");  // R9
      AST_RST_DROPS: assert property (@(posedge clk)
         !pin |=> !rst_q) else $error("reset held after pin low");            // R9
   end
endmodule

// File: rtl/mc_seq.sv
module mc_seq #(
   parameter int unsigned NUM_STATES = 6,
   parameter int unsigned ST_W       = $clog2(NUM_STATES)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            hold,
   input  logic            xdata_cyc,
   output logic [ST_W-1:0] st_q,
   output logic            p2_q,
   output logic [ST_W-1:0] st_n,
   output logic            p2_n,
   output logic            dcyc_n
);
   localparam logic [ST_W-1:0] LAST = ST_W'(NUM_STATES - 1);

   logic dcyc_q;
   logic wrap;

   assign wrap = p2_q && (st_q == LAST);

   always_comb begin
      st_n   = st_q;
      p2_n   = p2_q;
      dcyc_n = dcyc_q;
      if (rst) begin
         st_n   = '0;
         p2_n   = 1'b0;
         dcyc_n = 1'b0;
      end else if (!hold) begin
         // divide-by-two: phase flips every oscillator edge
         p2_n = ~p2_q;
         if (p2_q) st_n = wrap ? '0 : st_q + 1'b1;
         if (wrap) dcyc_n = xdata_cyc;
      end
   end

   always_ff @(posedge clk) begin
      st_q   <= st_n;
      p2_q   <= p2_n;
      dcyc_q <= dcyc_n;
   end

   AST_PHASE_FLIPS: assert property (@(posedge clk) disable iff (rst)
      !hold |=> (p2_q != $past(p2_q))) else $error("phase did not flip");     // R1
   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
      st_q <= LAST) else $error("state out of range");                        // R1
   AST_PDOWN_FREEZE: assert property (@(posedge clk) disable iff (rst)
      hold |=> ($stable(st_q) && $stable(p2_q))) else $error("moved in hold"); // R8
   AST_DCYC_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> $stable(dcyc_q)) else $error("data flag changed mid-cycle");  // R4
endmodule

// File: rtl/ale_ctl.sv
module ale_ctl #(
   parameter int unsigned            ADDR_W    = 8,
   parameter int unsigned            DATA_W    = 8,
   parameter logic [ADDR_W-1:0]      CTRL_ADDR = 8'h87,
   parameter int unsigned            OFF_BIT   = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ext_exec,
   input  logic              tbl_or_xmov,
   input  logic              idle,
   input  logic              pdown,
   output logic              off_eff
);
   if (OFF_BIT >= DATA_W) begin : g_chk_bit
      $error("ale_ctl: OFF_BIT outside data width");
   end

   logic off_q;
   logic hit;
   logic unused_wdata;

   assign unused_wdata = ^wdata;
   assign hit = we && (addr == CTRL_ADDR);

   always_ff @(posedge clk) begin
      if (rst)      off_q <= 1'b0;
      else if (hit) off_q <= wdata[OFF_BIT];
   end

   // suspension: instruction type, execution mode, power modes
   assign off_eff = off_q && !ext_exec && !tbl_or_xmov && !idle && !pdown;

   AST_RST_CLEARS_OFF: assert property (@(posedge clk)
      rst |=> !off_q) else $error("reset left ALE-off set");            // R9
   AST_FOREIGN_ADDR: assert property (@(posedge clk) disable iff (rst)
      (we && (addr != CTRL_ADDR)) |=> $stable(off_q))
      else $error("foreign write changed ALE-off");                     // R5
endmodule

// File: rtl/strobe_out.sv
module strobe_out
   import strobe_pkg::*;
#(
   parameter int unsigned NUM_STATES = 6,
   parameter int unsigned ST_W       = $clog2(NUM_STATES)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] st_n,
   input  logic            p2_n,
   input  logic            dcyc_n,
   input  logic            ext_exec,
   input  logic            idle,
   input  logic            pdown,
   input  logic            off_eff,
   output logic            ale_q,
   output logic            psen_n_q,
   output logic            weak_q
);
   localparam int unsigned NUM_WIN = 2;

   logic [NUM_WIN-1:0] ale_w, psen_w;
   strobe_mode_e mode;
   logic ale_d, psen_n_d, weak_d;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      localparam int unsigned S0 = win_first(w, NUM_STATES);
      logic skip_a;
      if (w == 0) begin : g_first
         assign skip_a = dcyc_n;       // first latch pulse dropped in data cycle
      end else begin : g_rest
         assign skip_a = 1'b0;
      end
      assign ale_w[w]  = ale_hit(int'(st_n), p2_n, S0, NUM_STATES) && !skip_a;
      assign psen_w[w] = psen_hit(int'(st_n), p2_n, S0, NUM_STATES) && !dcyc_n;
   end

   always_comb begin
      if (rst)        mode = SM_RESET;
      else if (pdown) mode = SM_PDOWN;
      else if (idle)  mode = SM_IDLE;
      else            mode = SM_RUN;
   end

   always_comb begin
      ale_d    = 1'b1;
      psen_n_d = 1'b1;
      weak_d   = 1'b0;
      case (mode)
         SM_RESET, SM_IDLE: ;
         SM_PDOWN: begin
            ale_d    = 1'b0;
            psen_n_d = 1'b0;
         end
         default: begin
            psen_n_d = !(ext_exec && (|psen_w));
            if (off_eff) weak_d = 1'b1;
            else         ale_d  = |ale_w;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      ale_q    <= ale_d;
      psen_n_q <= psen_n_d;
      weak_q   <= weak_d;
   end

   AST_WEAK_IS_HIGH: assert property (@(posedge clk) disable iff (rst)
      weak_q |-> ale_q) else $error("weak pullup with ALE low");          // R5
   AST_PSEN_INTERNAL: assert property (@(posedge clk) disable iff (rst)
      (!ext_exec && !pdown) |=> psen_n_q) else $error("fetch strobe internal"); // R3
   AST_XDATA_NO_PSEN: assert property (@(posedge clk) disable iff (rst)
      (dcyc_n && !pdown) |=> psen_n_q) else $error("fetch in data cycle");  // R4
   AST_PDOWN_LOW: assert property (@(posedge clk) disable iff (rst)
      pdown |=> (!ale_q && !psen_n_q && !weak_q)) else $error("pdown levels"); // R8
   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
      (idle && !pdown) |=> (ale_q && psen_n_q && !weak_q)) else $error("idle levels"); // R7
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
   parameter int unsigned       NUM_STATES  = 6,
   parameter int unsigned       RST_HOLD_MC = 2,
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       DATA_W      = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR   = 8'h87,
   parameter int unsigned       OFF_BIT     = 5,
   parameter int unsigned       ST_W        = $clog2(NUM_STATES)
) (
   input  logic              clk_osc,
   input  logic              rst_pin,
   input  logic              ext_exec,
   input  logic              xdata_cyc,
   input  logic              tbl_or_xmov,
   input  logic              idle_mode,
   input  logic              pdown_mode,
   input  logic              pcon_we,
   input  logic [ADDR_W-1:0] pcon_addr,
   input  logic [DATA_W-1:0] pcon_wdata,
   output logic              ale,
   output logic              ale_weak,
   output logic              psen_n,
   output logic [ST_W-1:0]   mc_state,
   output logic              mc_p2,
   output logic              mc_first
);
   localparam int unsigned CLKS_PER_MC = NUM_STATES * 2;
   localparam int unsigned HOLD_CLKS   = RST_HOLD_MC * CLKS_PER_MC;

   if ((NUM_STATES < 4) || (NUM_STATES % 2 != 0)) begin : g_chk_states
      $error("xbus_strobe_gen: NUM_STATES must be even and at least 4");
   end
   if (RST_HOLD_MC < 1) begin : g_chk_rst
      $error("xbus_strobe_gen: RST_HOLD_MC must be at least 1");
   end

   logic            rst_q;
   logic [ST_W-1:0] st_q, st_n;
   logic            p2_q, p2_n, dcyc_n;
   logic            off_eff;

   rst_qual #(.HOLD_CLKS(HOLD_CLKS)) u_rst (
      .clk(clk_osc), .pin(rst_pin), .rst_q(rst_q)
   );

   mc_seq #(.NUM_STATES(NUM_STATES), .ST_W(ST_W)) u_seq (
      .clk(clk_osc), .rst(rst_q), .hold(pdown_mode), .xdata_cyc(xdata_cyc),
      .st_q(st_q), .p2_q(p2_q), .st_n(st_n), .p2_n(p2_n), .dcyc_n(dcyc_n)
   );

   ale_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
             .OFF_BIT(OFF_BIT)) u_ctl (
      .clk(clk_osc), .rst(rst_q), .we(pcon_we), .addr(pcon_addr),
      .wdata(pcon_wdata), .ext_exec(ext_exec), .tbl_or_xmov(tbl_or_xmov),
      .idle(idle_mode), .pdown(pdown_mode), .off_eff(off_eff)
   );

   strobe_out #(.NUM_STATES(NUM_STATES), .ST_W(ST_W)) u_out (
      .clk(clk_osc), .rst(rst_q), .st_n(st_n), .p2_n(p2_n), .dcyc_n(dcyc_n),
      .ext_exec(ext_exec), .idle(idle_mode), .pdown(pdown_mode),
      .off_eff(off_eff), .ale_q(ale), .psen_n_q(psen_n), .weak_q(ale_weak)
   );

   assign mc_state = st_q;
   assign mc_p2    = p2_q;
   assign mc_first = (st_q == '0) && !p2_q;
endmodule

// File: tb/sim_xbus_strobe_gen.sv
module sim_xbus_strobe_gen;
   logic       clk = 1'b0;
   logic       rst_pin = 1'b1;
   logic       ext_exec = 0, xdata_cyc = 0, tbl_or_xmov = 0, idle_mode = 0, pdown_mode = 0;
   logic       pcon_we = 0;
   logic [7:0] pcon_addr = 0, pcon_wdata = 0;
   logic       ale, ale_weak, psen_n, mc_p2, mc_first;
   logic [2:0] mc_state;
   int         checks = 0, errors = 0, cyc = 0;

   always #2 clk = ~clk;   // 250 MHz

   xbus_strobe_gen u0 (
      .clk_osc(clk), .rst_pin(rst_pin), .ext_exec(ext_exec), .xdata_cyc(xdata_cyc),
      .tbl_or_xmov(tbl_or_xmov), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
      .pcon_we(pcon_we), .pcon_addr(pcon_addr), .pcon_wdata(pcon_wdata),
      .ale(ale), .ale_weak(ale_weak), .psen_n(psen_n),
      .mc_state(mc_state), .mc_p2(mc_p2), .mc_first(mc_first)
   );

   // fields: [4] ext_exec, [3] xdata_cyc, [2] tbl_or_xmov, [1] idle, [0] ALE-off
   localparam int NV = 10;
   localparam logic [4:0] VEC [NV] = '{
      5'b00000, 5'b10000, 5'b11000, 5'b01000, 5'b00001,
      5'b00101, 5'b10001, 5'b01101, 5'b00011, 5'b11010 };

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic string vtag(input logic [4:0] v);
      if (v[1])                     return "R7";
      if (v[0] && !v[4] && !v[2])   return "R5";
      if (v[0])                     return "R6";
      if (v[3])                     return "R4";
      if (v[4])                     return "R3";
      return "R2";
   endfunction

   task automatic expect_at(input logic [4:0] v, input int idx,
                            output logic ea, output logic ep, output logic ew);
      logic win_a, win_b, fet;
      win_a = (idx == 1) || (idx == 2);
      win_b = (idx == 7) || (idx == 8);
      fet   = (idx >= 1 && idx <= 3) || (idx >= 7 && idx <= 9);
      if (v[1]) begin
         ea = 1; ep = 1; ew = 0;
      end else if (v[0] && !v[4] && !v[2]) begin
         ea = 1; ep = 1; ew = 1;
      end else begin
         ea = (win_a && !v[3]) || win_b;
         ep = !(v[4] && !v[3] && fet);
         ew = 0;
      end
   endtask

   task automatic set_flags(input logic [4:0] v);
      @(negedge clk);
      ext_exec = v[4]; xdata_cyc = v[3]; tbl_or_xmov = v[2]; idle_mode = v[1];
   endtask

   task automatic pcon_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pcon_we = 1; pcon_addr = a; pcon_wdata = d;
      @(negedge clk);
      pcon_we = 0;
   endtask

   task automatic capture(input logic [4:0] v, input string tag);
      logic ea, ep, ew;
      int idx;
      do @(negedge clk); while (!mc_first);
      @(negedge clk);
      do @(negedge clk); while (!mc_first);
      for (int k = 0; k < 12; k++) begin
         if (k > 0) @(negedge clk);
         idx = int'(mc_state) * 2 + int'(mc_p2);
         chk("R1", "state/phase index", idx, k);
         expect_at(v, k, ea, ep, ew);
         chk(tag, $sformatf("ale idx %0d", k), int'(ale), int'(ea));
         chk(tag, $sformatf("psen_n idx %0d", k), int'(psen_n), int'(ep));
         chk(tag, $sformatf("ale_weak idx %0d", k), int'(ale_weak), int'(ew));
      end
   endtask

   initial begin
      int s0, p0, rises, idx0;
      logic prev;
      // R9 reset state
      repeat (30) @(negedge clk);
      chk("R9", "reset ale", int'(ale), 1);
      chk("R9", "reset psen_n", int'(psen_n), 1);
      chk("R9", "reset ale_weak", int'(ale_weak), 0);
      chk("R9", "reset state", int'(mc_state), 0);
      chk("R9", "reset phase", int'(mc_p2), 0);
      rst_pin = 0;

      // vector table
      for (int i = 0; i < NV; i++) begin
         set_flags(VEC[i]);
         pcon_wr(8'h87, {2'b00, VEC[i][0], 5'b00000});
         capture(VEC[i], vtag(VEC[i]));
      end

      // R2 ALE rate: 10 rising edges in 60 clocks
      set_flags(5'b00000);
      pcon_wr(8'h87, 8'h00);
      prev = ale; rises = 0;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (ale && !prev) rises++;
         prev = ale;
      end
      chk("R2", "ALE rises in 60 clocks", rises, 10);

      // R5 foreign address ignored
      pcon_wr(8'h86, 8'h20);
      capture(5'b00000, "R5");
      // R5 other bits of the right address do not set ALE-off
      pcon_wr(8'h87, 8'hDF);
      capture(5'b00000, "R5");

      // R10 mode latency: idle reaches strobes on the next edge
      set_flags(5'b10000);
      do @(negedge clk); while (!(mc_state == 2 && mc_p2 == 0));
      idle_mode = 1;
      @(negedge clk);
      chk("R10", "idle ale one edge later", int'(ale), 1);
      chk("R10", "idle psen_n one edge later", int'(psen_n), 1);
      idle_mode = 0; ext_exec = 0;
      // R10 register write reaches ALE on the second edge
      do @(negedge clk); while (!(mc_state == 5 && mc_p2 == 1));
      pcon_we = 1; pcon_addr = 8'h87; pcon_wdata = 8'h20;
      @(negedge clk);
      pcon_we = 0;
      chk("R10", "weak after first edge", int'(ale_weak), 0);
      @(negedge clk);
      chk("R10", "weak after second edge", int'(ale_weak), 1);

      // R9 short pulse ignored, ALE-off survives
      @(negedge clk);
      rst_pin = 1;
      repeat (23) @(posedge clk);
      @(negedge clk);
      rst_pin = 0;
      repeat (3) @(negedge clk);
      chk("R9", "23-clock pulse ignored (weak kept)", int'(ale_weak), 1);
      // R9 full reset clears ALE-off
      rst_pin = 1;
      repeat (30) @(negedge clk);
      chk("R9", "reset ale_weak", int'(ale_weak), 0);
      chk("R9", "reset held at S1", int'(mc_state), 0);
      rst_pin = 0;
      capture(5'b00000, "R9");

      // R8 power-down with idle: freeze and low levels
      set_flags(5'b10010);
      pdown_mode = 1;
      @(negedge clk);
      s0 = int'(mc_state); p0 = int'(mc_p2);
      idx0 = s0 * 2 + p0;
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk("R8", "state frozen", int'(mc_state) * 2 + int'(mc_p2), idx0);
         chk("R8", "ale low", int'(ale), 0);
         chk("R8", "psen_n low", int'(psen_n), 0);
         chk("R8", "ale_weak low", int'(ale_weak), 0);
      end
      pdown_mode = 0; idle_mode = 0;
      @(negedge clk);
      chk("R8", "sequencer resumes", int'(mc_state) * 2 + int'(mc_p2), (idx0 + 1) % 12);
      capture(5'b10000, "R8");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule